// File: doc/BRIEF.md
# Parallel DAC Bus Access Sequencer

This block sits on the host side of a 16-bit parallel digital-to-analog converter. It turns single commands into correctly timed pin activity. A command is one of write, read, load or reset. The pins are an active-low chip select, a read/write line, an active-low load strobe, an active-low converter reset and a reset-select level. The data bus is split into an output word, an output enable and an input word, so that a tristate pad can be placed outside the block. Commands arrive over a valid/ready handshake. Read results come back as a one-cycle valid pulse with the captured word.

Every timing rule is a parameter given in nanoseconds. A clock-period parameter turns each rule into a cycle count. The sequencer then holds each phase for that many cycles: strobe widths, setup and hold windows, the wait for read data, and the gaps between accesses. A second build variant serves a write-only bus where chip select and read/write are tied low. An optional flag stays busy for the output settling time after each load.

Top module: `dac_bus_seq`

## Requirements
- R1: While rst_n is low and after its release, until the first command: dac_cs_n=1 (0 in tied mode), dac_rw=0, dac_ldac_n=1, dac_rst_n=1, dac_rstsel=0, dac_db_oe=0 (1 in tied mode), rd_valid=0, settle_busy=0 and cmd_ready=1.
- R2: Each nanosecond rule becomes ceil(ns / CLK_NS) cycles, and never fewer than one. The write setup, write strobe, read strobe, load-low and reset-low phases last exactly their converted counts. A 0 ns write setup gives one cycle of driven data before chip select falls.
- R3: Write (op 00): dac_rw is 0 and dac_db_oe is 1 with the command word on dac_db_out before dac_cs_n falls. dac_cs_n stays low for at least the 20 ns write width. For at least max(10 ns, 15 ns) after dac_cs_n rises, dac_rw stays 0 and the word stays driven.
- R4: Read (op 01): dac_rw is 1 for at least 30 ns before dac_cs_n falls, and dac_db_oe is 0 whenever dac_rw is 1. dac_cs_n stays low for max(40 ns, 80 ns). dac_db_in is sampled in the last low cycle and returned on rd_data with a one-cycle rd_valid. dac_rw stays 1 for at least 10 ns after dac_cs_n rises.
- R5: dac_cs_n stays high for at least 80 ns between two chip-select low pulses.
- R6: Load (op 10): dac_ldac_n is low for at least 40 ns and high for at least 40 ns between loads. Its rising edge comes at least 10 ns after the latest chip-select fall, or in tied mode after the latest data update.
- R7: dac_cs_n does not fall within 50 ns after a rising edge of dac_ldac_n.
- R8: Reset (op 11): dac_rst_n is low for at least 40 ns and then high for at least 40 ns before another command starts. dac_rstsel carries the command's cmd_rsel from the start of the pulse until at least 20 ns after the rising edge. dac_db_oe is 0 during the pulse.
- R9: A command is taken in a cycle with cmd_valid=1 and cmd_ready=1. cmd_ready is 1 only when the sequencer is idle and every gap timer has expired. It is 0 in the cycle after a command that starts bus activity. With cmd_valid=0 the pins stay idle.
- R10: When TIED_MODE=1, dac_cs_n and dac_rw stay 0. A write updates dac_db_out with dac_db_oe=1. A read command is ignored: rd_valid stays 0 and dac_db_out is unchanged.
- R11: When SETTLE_EN=1, settle_busy rises together with each rising edge of dac_ldac_n. It stays high for ceil(SETTLE_NS / CLK_NS) cycles after the latest such edge and falls in the next cycle. When SETTLE_EN=0 it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 00 write, 01 read, 10 load, 11 reset |
| cmd_data | input | DW | Word for a write command |
| cmd_rsel | input | 1 | Reset-select level for a reset command |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_rw | output | 1 | 1 read, 0 write |
| dac_ldac_n | output | 1 | Load strobe, active low |
| dac_rst_n | output | 1 | Converter reset, active low |
| dac_rstsel | output | 1 | Reset-select level |
| dac_db_out | output | DW | Bus word driven to the converter |
| dac_db_oe | output | 1 | Bus output enable |
| dac_db_in | input | DW | Bus word read from the converter |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DW | Captured read word |
| settle_busy | output | 1 | Output still settling after a load |

## Verification
The bench models a converter whose read data turns valid only after chip select has been low for the full 80 ns. A sequencer that samples one cycle early returns a garbage word instead of the stored one. It measures every chip-select, load and reset pulse, and the gaps between them, against its own ceiling conversion. A design that skipped the read setup, dropped the write hold, or let chip select fall too soon after a load or a previous access would show a short count. Back-to-back loads check that the settle flag restarts from the latest load rather than the first. Reset-select is compared after the reset edge, and a tied-mode instance checks that reads there are ignored.

// File: rtl/dac_bus_seq_pkg.sv
package dac_bus_seq_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_READ  = 2'b01,
    OP_LOAD  = 2'b10,
    OP_RESET = 2'b11
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WR_SU,
    ST_WR_STB,
    ST_WR_HD,
    ST_RD_SU,
    ST_RD_STB,
    ST_RD_HD,
    ST_LD_LO,
    ST_RS_LO,
    ST_RS_HI
  } st_e;

  typedef struct packed {
    logic cs_n;
    logic rw;
    logic ldac_n;
    logic rst_n;
    logic oe;
  } pins_t;

  // ceiling of ns over the period, at least one cycle
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned bits_for(int unsigned v);
    int unsigned b;
    b = $clog2(v + 1);
    return (b < 1) ? 1 : b;
  endfunction

endpackage

// File: rtl/dac_bus_seq_timer.sv
module dac_bus_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         idle
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign idle = (cnt == '0);

  // R2: a running count only ever moves down by one
  p_timer_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/dac_bus_seq_settle.sv
module dac_bus_seq_settle #(
  parameter int EN  = 1,
  parameter int CYC = 2000,
  parameter int W   = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  generate
    if (EN != 0) begin : g_on
      logic idle;
      dac_bus_seq_timer #(.W(W)) i_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .load (start),
        .val  (W'(CYC)),
        .idle (idle)
      );
      assign busy = !idle;

      // R11: a load edge always raises the flag
      p_settle_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    end else begin : g_off
      logic unused_in;
      assign unused_in = clk ^ rst_n ^ start;
      assign busy = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/dac_bus_seq_drive.sv
module dac_bus_seq_drive
  import dac_bus_seq_pkg::*;
#(
  parameter int TIED_MODE = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  st_e   state,
  output pins_t pins
);

  logic in_rst;
  assign in_rst = (state == ST_RS_LO) || (state == ST_RS_HI);

  assign pins.ldac_n = (state != ST_LD_LO);
  assign pins.rst_n  = (state != ST_RS_LO);

  generate
    if (TIED_MODE != 0) begin : g_tied
      assign pins.cs_n = 1'b0;
      assign pins.rw   = 1'b0;
      assign pins.oe   = !in_rst;
    end else begin : g_full
      assign pins.cs_n = !((state == ST_WR_STB) || (state == ST_RD_STB));
      assign pins.rw   = (state == ST_RD_SU) || (state == ST_RD_STB) ||
                         (state == ST_RD_HD);
      assign pins.oe   = (state == ST_WR_SU) || (state == ST_WR_STB) ||
                         (state == ST_WR_HD);
    end
  endgenerate

  // R4: the bus is never driven while reading
  p_no_drive_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pins.rw |-> !pins.oe);

  // R10: tied mode keeps select and direction low
  p_tied_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (TIED_MODE != 0) |-> (!pins.cs_n && !pins.rw));

  // R8: converter reset never overlaps a driven bus
  p_rst_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pins.rst_n |-> !pins.oe);

endmodule

// File: rtl/dac_bus_seq.sv
module dac_bus_seq
  import dac_bus_seq_pkg::*;
#(
  parameter int DW          = 16,
  parameter int CLK_NS      = 5,
  parameter int TIED_MODE   = 0,
  parameter int SETTLE_EN   = 1,
  parameter int T_WR_SU     = 0,
  parameter int T_WR_PW     = 20,
  parameter int T_WR_RW_HD  = 10,
  parameter int T_WR_DAT_HD = 15,
  parameter int T_RD_SU     = 30,
  parameter int T_RD_PW     = 40,
  parameter int T_RD_DLY    = 80,
  parameter int T_RD_HD     = 10,
  parameter int T_CS_GAP    = 80,
  parameter int T_LD_LO     = 40,
  parameter int T_LD_HI     = 40,
  parameter int T_LD_SU     = 10,
  parameter int T_LD_CS     = 50,
  parameter int T_RST_LO    = 40,
  parameter int T_RST_HI    = 40,
  parameter int T_RSEL_HD   = 20,
  parameter int SETTLE_NS   = 10000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  input  logic          cmd_rsel,
  output logic          dac_cs_n,
  output logic          dac_rw,
  output logic          dac_ldac_n,
  output logic          dac_rst_n,
  output logic          dac_rstsel,
  output logic [DW-1:0] dac_db_out,
  output logic          dac_db_oe,
  input  logic [DW-1:0] dac_db_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          settle_busy
);

  localparam int unsigned P      = CLK_NS;
  localparam int unsigned C_WSU  = ns_to_cyc(T_WR_SU, P);
  localparam int unsigned C_WPW  = ns_to_cyc(T_WR_PW, P);
  localparam int unsigned C_WHD  = max2(ns_to_cyc(T_WR_RW_HD, P), ns_to_cyc(T_WR_DAT_HD, P));
  localparam int unsigned C_RSU  = ns_to_cyc(T_RD_SU, P);
  localparam int unsigned C_RPW  = max2(ns_to_cyc(T_RD_PW, P), ns_to_cyc(T_RD_DLY, P));
  localparam int unsigned C_RHD  = ns_to_cyc(T_RD_HD, P);
  localparam int unsigned C_CSG  = ns_to_cyc(T_CS_GAP, P);
  localparam int unsigned C_LDLO = ns_to_cyc(T_LD_LO, P);
  localparam int unsigned C_LDHI = ns_to_cyc(T_LD_HI, P);
  localparam int unsigned C_LDSU = ns_to_cyc(T_LD_SU, P);
  localparam int unsigned C_LDCS = ns_to_cyc(T_LD_CS, P);
  localparam int unsigned C_RSLO = ns_to_cyc(T_RST_LO, P);
  localparam int unsigned C_RSHI = max2(ns_to_cyc(T_RST_HI, P), ns_to_cyc(T_RSEL_HD, P));
  localparam int unsigned C_SET  = ns_to_cyc(SETTLE_NS, P);

  localparam int unsigned M_PH  = max2(max2(max2(C_WSU, C_WPW), max2(C_WHD, C_RSU)),
                                       max2(max2(C_RPW, C_RHD), max2(C_LDLO, max2(C_RSLO, C_RSHI))));
  localparam int unsigned M_GAP = max2(max2(C_CSG, C_LDHI), max2(C_LDSU, C_LDCS));
  localparam int TW = bits_for(max2(M_PH, M_GAP));
  localparam int SW = bits_for(C_SET);

  // ---------------------------------------------------------------- state
  st_e   state, st_nxt;
  op_e   op_w;
  pins_t pins;
  logic  ph_idle, cs_gap_idle, ld_cs_idle, ld_hi_idle, ld_su_idle;
  logic  accept, st_chg;
  logic  ev_cs_fall, ev_cs_rise, ev_ld_rise, ev_wr_take;
  logic [DW-1:0] db_q;
  logic          rsel_q;

  assign op_w = op_e'(cmd_op);

  function automatic int unsigned ph_len(st_e s);
    case (s)
      ST_WR_SU:  return C_WSU;
      ST_WR_STB: return C_WPW;
      ST_WR_HD:  return C_WHD;
      ST_RD_SU:  return C_RSU;
      ST_RD_STB: return C_RPW;
      ST_RD_HD:  return C_RHD;
      ST_LD_LO:  return C_LDLO;
      ST_RS_LO:  return C_RSLO;
      ST_RS_HI:  return C_RSHI;
      default:   return 1;
    endcase
  endfunction

  assign cmd_ready = (state == ST_IDLE) && cs_gap_idle && ld_cs_idle &&
                     ld_hi_idle;
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    st_nxt = state;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          case (op_w)
            OP_WRITE: st_nxt = ST_WR_SU;
            OP_READ:  st_nxt = (TIED_MODE != 0) ? ST_IDLE : ST_RD_SU;
            OP_LOAD:  st_nxt = ST_LD_LO;
            default:  st_nxt = ST_RS_LO;
          endcase
        end
      end
      ST_WR_SU:  if (ph_idle) st_nxt = (TIED_MODE != 0) ? ST_IDLE : ST_WR_STB;
      ST_WR_STB: if (ph_idle) st_nxt = ST_WR_HD;
      ST_WR_HD:  if (ph_idle) st_nxt = ST_IDLE;
      ST_RD_SU:  if (ph_idle) st_nxt = ST_RD_STB;
      ST_RD_STB: if (ph_idle) st_nxt = ST_RD_HD;
      ST_RD_HD:  if (ph_idle) st_nxt = ST_IDLE;
      ST_LD_LO:  if (ph_idle && ld_su_idle) st_nxt = ST_IDLE;
      ST_RS_LO:  if (ph_idle) st_nxt = ST_RS_HI;
      ST_RS_HI:  if (ph_idle) st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  assign st_chg = (st_nxt != state);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= st_nxt;
  end

  // ---------------------------------------------------------------- events
  assign ev_cs_fall = ((state == ST_WR_SU) && (st_nxt == ST_WR_STB)) ||
                      ((state == ST_RD_SU) && (st_nxt == ST_RD_STB));
  assign ev_cs_rise = ((state == ST_WR_STB) || (state == ST_RD_STB)) && st_chg;
  assign ev_ld_rise = (state == ST_LD_LO) && st_chg;
  assign ev_wr_take = accept && (op_w == OP_WRITE);

  // ---------------------------------------------------------------- timers
  dac_bus_seq_timer #(.W(TW)) i_ph (
    .clk(clk), .rst_n(rst_n), .load(st_chg),
    .val(TW'(ph_len(st_nxt) - 1)), .idle(ph_idle));

  dac_bus_seq_timer #(.W(TW)) i_cs_gap (
    .clk(clk), .rst_n(rst_n), .load(ev_cs_rise),
    .val(TW'(C_CSG)), .idle(cs_gap_idle));

  dac_bus_seq_timer #(.W(TW)) i_ld_cs (
    .clk(clk), .rst_n(rst_n), .load(ev_ld_rise),
    .val(TW'(C_LDCS)), .idle(ld_cs_idle));

  dac_bus_seq_timer #(.W(TW)) i_ld_hi (
    .clk(clk), .rst_n(rst_n), .load(ev_ld_rise),
    .val(TW'(C_LDHI)), .idle(ld_hi_idle));

  dac_bus_seq_timer #(.W(TW)) i_ld_su (
    .clk(clk), .rst_n(rst_n),
    .load((TIED_MODE != 0) ? ev_wr_take : ev_cs_fall),
    .val(TW'(C_LDSU)), .idle(ld_su_idle));

  dac_bus_seq_settle #(.EN(SETTLE_EN), .CYC(int'(C_SET)), .W(SW)) i_settle (
    .clk(clk), .rst_n(rst_n), .start(ev_ld_rise), .busy(settle_busy));

  // ---------------------------------------------------------------- data path
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_q     <= '0;
      rsel_q   <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (ev_wr_take) db_q <= cmd_data;
      if (accept && (op_w == OP_RESET)) rsel_q <= cmd_rsel;
      rd_valid <= 1'b0;
      if ((state == ST_RD_STB) && ph_idle) begin
        rd_data  <= dac_db_in;
        rd_valid <= 1'b1;
      end
    end
  end

  dac_bus_seq_drive #(.TIED_MODE(TIED_MODE)) i_drive (
    .clk(clk), .rst_n(rst_n), .state(state), .pins(pins));

  assign dac_cs_n   = pins.cs_n;
  assign dac_rw     = pins.rw;
  assign dac_ldac_n = pins.ldac_n;
  assign dac_rst_n  = pins.rst_n;
  assign dac_db_oe  = pins.oe;
  assign dac_db_out = db_q;
  assign dac_rstsel = rsel_q;

  // ---------------------------------------------------------------- checks
  // R5, R7: select only falls once both gap timers have run out
  p_cs_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_cs_n) |-> (cs_gap_idle && ld_cs_idle));

  // R4: read data is taken while select is still low
  p_rd_in_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!dac_cs_n) && dac_cs_n));

  // R6: load rises only after its setup window
  p_ld_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_ldac_n) |-> $past(ld_su_idle));

  // R8: reset-select does not move right after the reset edge
  p_rsel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_rst_n) |=> $stable(dac_rstsel));

  // R9: a command that starts bus work closes the handshake
  p_accept_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ((TIED_MODE == 0) || (op_w != OP_READ))) |=> !cmd_ready);

endmodule

// File: tb/test_dac_bus_seq.sv
module test_dac_bus_seq;

  localparam int PER = 5;
  localparam int DW  = 16;

  function automatic int cyc(int ns);
    int n;
    n = 0;
    while (n * PER < ns) n++;
    if (n == 0) n = 1;
    return n;
  endfunction

  localparam int E_WSU  = cyc(0);
  localparam int E_WPW  = cyc(20);
  localparam int E_WHD  = (cyc(15) > cyc(10)) ? cyc(15) : cyc(10);
  localparam int E_RSU  = cyc(30);
  localparam int E_RDLY = cyc(80);
  localparam int E_RPW  = (cyc(80) > cyc(40)) ? cyc(80) : cyc(40);
  localparam int E_RHD  = cyc(10);
  localparam int E_CSG  = cyc(80);
  localparam int E_LDLO = cyc(40);
  localparam int E_LDHI = cyc(40);
  localparam int E_LDCS = cyc(50);
  localparam int E_RSLO = cyc(40);
  localparam int E_RSHI = cyc(40);
  localparam int E_RSHD = cyc(20);
  localparam int E_SET  = cyc(10000);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------------------------------------------------------- main DUT
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [DW-1:0] cmd_data = '0;
  logic          cmd_rsel = 1'b0;
  logic          cmd_ready, dac_cs_n, dac_rw, dac_ldac_n, dac_rst_n, dac_rstsel;
  logic [DW-1:0] dac_db_out, dac_db_in, rd_data;
  logic          dac_db_oe, rd_valid, settle_busy;

  dac_bus_seq #(.CLK_NS(PER)) i_dac_bus_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_rsel(cmd_rsel),
    .dac_cs_n(dac_cs_n), .dac_rw(dac_rw), .dac_ldac_n(dac_ldac_n),
    .dac_rst_n(dac_rst_n), .dac_rstsel(dac_rstsel), .dac_db_out(dac_db_out),
    .dac_db_oe(dac_db_oe), .dac_db_in(dac_db_in), .rd_valid(rd_valid),
    .rd_data(rd_data), .settle_busy(settle_busy));

  // ---------------------------------------------------------------- tied DUT
  logic          t_valid = 1'b0;
  logic [1:0]    t_op = 2'b00;
  logic [DW-1:0] t_data = '0;
  logic          t_ready, t_cs_n, t_rw, t_ldac_n, t_rst_n, t_rstsel;
  logic [DW-1:0] t_db_out, t_rd_data;
  logic          t_db_oe, t_rd_valid, t_busy;

  dac_bus_seq #(.CLK_NS(PER), .TIED_MODE(1), .SETTLE_EN(0)) i_tied (
    .clk(clk), .rst_n(rst_n), .cmd_valid(t_valid), .cmd_ready(t_ready),
    .cmd_op(t_op), .cmd_data(t_data), .cmd_rsel(1'b0),
    .dac_cs_n(t_cs_n), .dac_rw(t_rw), .dac_ldac_n(t_ldac_n),
    .dac_rst_n(t_rst_n), .dac_rstsel(t_rstsel), .dac_db_out(t_db_out),
    .dac_db_oe(t_db_oe), .dac_db_in(16'h0000), .rd_valid(t_rd_valid),
    .rd_data(t_rd_data), .settle_busy(t_busy));

  // ---------------------------------------------------------------- monitor and converter model
  logic [DW-1:0] mem = '0;
  logic [DW-1:0] exp_wdata = '0;
  logic          exp_rsel = 1'b0;
  logic [DW-1:0] rd_got = '0;
  bit            got_rd = 0;
  bit            mon_on = 0;
  logic p_cs = 1, p_rw = 0, p_ld = 1, p_rs = 1, p_busy = 0, p_oe = 0;
  int cs_lo = 0, cs_hi = 0, rw_cnt = 0, oe_cnt = 0, ld_lo = 0, ld_hi = 0;
  int since_ld = 1000, rs_lo = 0, since_rs = 1000;
  bit seen_rise = 0, seen_ld = 0, seen_rs = 0, last_wr = 0;
  logic rsel_r = 0;
  bit t_rdv_seen = 0;

  assign dac_db_in = (!dac_cs_n && dac_rw && cs_lo >= E_RDLY) ? mem : 16'hBAD0;

  always @(negedge clk) begin
    if (t_rd_valid) t_rdv_seen = 1;
    if (rst_n && mon_on) begin
      rw_cnt   = (dac_rw != p_rw) ? 1 : rw_cnt + 1;
      oe_cnt   = (dac_db_oe != p_oe) ? 1 : oe_cnt + 1;
      since_ld = since_ld + 1;
      since_rs = since_rs + 1;
      if (dac_cs_n != p_cs) begin
        if (!dac_cs_n) begin
          if (seen_rise) chk(cs_hi >= E_CSG, "R5 cs high gap", cs_hi, E_CSG);
          chk(since_ld > E_LDCS, "R7 load to select", since_ld, E_LDCS);
          if (seen_rs) chk(since_rs > E_RSHI, "R8 reset high", since_rs, E_RSHI);
          if (dac_rw) begin
            chk(rw_cnt > E_RSU, "R4 read setup", rw_cnt, E_RSU);
          end else begin
            chk(dac_db_oe && dac_db_out == exp_wdata, "R3 write data", dac_db_out, exp_wdata);
            chk(oe_cnt == E_WSU + 1, "R2 write setup", oe_cnt, E_WSU + 1);
          end
          cs_lo = 1;
        end else begin
          if (!p_rw) begin
            chk(cs_lo >= E_WPW, "R3 write strobe", cs_lo, E_WPW);
            chk(cs_lo == E_WPW, "R2 write strobe", cs_lo, E_WPW);
            mem = dac_db_out;
            last_wr = 1;
          end else begin
            chk(cs_lo == E_RPW, "R2 read strobe", cs_lo, E_RPW);
            last_wr = 0;
          end
          cs_hi = 1;
          seen_rise = 1;
        end
      end else if (!dac_cs_n) cs_lo = cs_lo + 1;
      else cs_hi = cs_hi + 1;

      if (seen_rise && dac_cs_n && last_wr && cs_hi <= E_WHD)
        chk(!dac_rw && dac_db_oe && dac_db_out == mem, "R3 write hold", dac_db_out, mem);
      if (seen_rise && dac_cs_n && !last_wr && cs_hi <= E_RHD)
        chk(dac_rw, "R4 read hold", dac_rw, 1);
      if (!dac_cs_n && dac_rw) chk(!dac_db_oe, "R4 bus off", dac_db_oe, 0);

      if (dac_ldac_n != p_ld) begin
        if (dac_ldac_n) begin
          chk(ld_lo == E_LDLO, "R6 load low", ld_lo, E_LDLO);
          chk(settle_busy, "R11 busy rise", settle_busy, 1);
          since_ld = 1;
          ld_hi = 1;
          seen_ld = 1;
        end else begin
          if (seen_ld) chk(ld_hi >= E_LDHI, "R6 load high", ld_hi, E_LDHI);
          ld_lo = 1;
        end
      end else if (!dac_ldac_n) ld_lo = ld_lo + 1;
      else ld_hi = ld_hi + 1;

      if (p_busy && !settle_busy)
        chk(since_ld == E_SET + 1, "R11 busy length", since_ld, E_SET + 1);

      if (dac_rst_n != p_rs) begin
        if (dac_rst_n) begin
          chk(rs_lo == E_RSLO, "R8 reset low", rs_lo, E_RSLO);
          chk(dac_rstsel == exp_rsel, "R8 reset select", dac_rstsel, exp_rsel);
          rsel_r = dac_rstsel;
          mem = dac_rstsel ? 16'h8000 : 16'h0000;
          since_rs = 1;
          seen_rs = 1;
        end else begin
          chk(!dac_db_oe, "R8 bus off in reset", dac_db_oe, 0);
          rs_lo = 1;
        end
      end else if (!dac_rst_n) rs_lo = rs_lo + 1;
      if (seen_rs && dac_rst_n && since_rs <= E_RSHD)
        chk(dac_rstsel == rsel_r, "R8 select hold", dac_rstsel, rsel_r);

      if (rd_valid) begin
        got_rd = 1;
        rd_got = rd_data;
      end
    end
    p_cs = dac_cs_n; p_rw = dac_rw; p_ld = dac_ldac_n; p_rs = dac_rst_n;
    p_busy = settle_busy; p_oe = dac_db_oe;
  end

  // ---------------------------------------------------------------- watchdog
  int cyc_cnt = 0;
  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == 100000) begin
      fails++;
      $display("FAIL R9 watchdog actual=hang expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // ---------------------------------------------------------------- tasks
  task automatic issue(input logic [1:0] op, input logic [DW-1:0] d, input logic rs);
    @(negedge clk);
    cmd_op = op; cmd_data = d; cmd_rsel = rs; cmd_valid = 1'b1;
    if (op == 2'b00) exp_wdata = d;
    if (op == 2'b11) exp_rsel = rs;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R9 ready drop", cmd_ready, 0);
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic t_issue(input logic [1:0] op, input logic [DW-1:0] d);
    @(negedge clk);
    t_op = op; t_data = d; t_valid = 1'b1;
    while (!t_ready) @(negedge clk);
    @(negedge clk);
    t_valid = 1'b0;
  endtask

  // op[34:33] data[32:17] rsel[16] expected read[15:0]
  localparam int NV = 12;
  localparam logic [34:0] VEC [NV] = '{
    {2'b00, 16'h1234, 1'b0, 16'h0000},
    {2'b01, 16'h0000, 1'b0, 16'h1234},
    {2'b10, 16'h0000, 1'b0, 16'h0000},
    {2'b00, 16'hFFFF, 1'b0, 16'h0000},
    {2'b10, 16'h0000, 1'b0, 16'h0000},
    {2'b01, 16'h0000, 1'b0, 16'hFFFF},
    {2'b11, 16'h0000, 1'b1, 16'h0000},
    {2'b01, 16'h0000, 1'b0, 16'h8000},
    {2'b00, 16'h0001, 1'b0, 16'h0000},
    {2'b01, 16'h0000, 1'b0, 16'h0001},
    {2'b11, 16'h0000, 1'b0, 16'h0000},
    {2'b01, 16'h0000, 1'b0, 16'h0000}
  };

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(dac_cs_n && !dac_rw && dac_ldac_n && dac_rst_n && !dac_db_oe,
        "R1 pins in reset", {dac_cs_n, dac_rw, dac_ldac_n, dac_rst_n, dac_db_oe}, 5'b10110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !rd_valid && !settle_busy && !dac_rstsel && dac_cs_n,
        "R1 idle after reset", {cmd_ready, rd_valid, settle_busy, dac_rstsel, dac_cs_n}, 5'b10001);
    chk(!t_cs_n && !t_rw && t_db_oe, "R1 tied idle", {t_cs_n, t_rw, t_db_oe}, 3'b001);
    mon_on = 1;

    for (int i = 0; i < NV; i++) begin
      got_rd = 0;
      issue(VEC[i][34:33], VEC[i][32:17], VEC[i][16]);
      wait_ready();
      if (VEC[i][34:33] == 2'b01) begin
        chk(got_rd, "R4 read pulse", got_rd, 1);
        chk(rd_got == VEC[i][15:0], "R4 read word", rd_got, VEC[i][15:0]);
      end
    end

    // R9: no valid, no activity
    begin
      bit quiet;
      quiet = 1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (!dac_cs_n || !dac_ldac_n || !dac_rst_n || !cmd_ready) quiet = 0;
      end
      chk(quiet, "R9 idle without valid", quiet, 1);
    end

    // R11: wait for the settle flag to drop (checked by the monitor)
    while (settle_busy) @(negedge clk);
    @(negedge clk);
    chk(!settle_busy, "R11 busy low", settle_busy, 0);

    // R10 tied mode
    t_issue(2'b00, 16'hA5A5);
    repeat (4) @(negedge clk);
    chk(t_db_out == 16'hA5A5 && t_db_oe, "R10 tied write", t_db_out, 16'hA5A5);
    t_rdv_seen = 0;
    t_issue(2'b01, 16'h0000);
    repeat (30) @(negedge clk);
    chk(!t_rdv_seen && t_db_out == 16'hA5A5 && !t_cs_n && !t_rw,
        "R10 tied read ignored", t_db_out, 16'hA5A5);
    t_issue(2'b10, 16'h0000);
    begin
      int lo;
      lo = 1;
      while (!t_ldac_n) begin
        @(negedge clk);
        if (!t_ldac_n) lo++;
      end
      chk(lo == E_LDLO, "R6 tied load low", lo, E_LDLO);
    end
    chk(t_db_out == 16'hA5A5 && !t_cs_n, "R10 tied data at load", t_db_out, 16'hA5A5);
    chk(!t_busy, "R11 flag disabled", t_busy, 0);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule